// File: doc/BRIEF.md
# Prioritized Five-Source Interrupt Controller

This block keeps the interrupt enable mask and the pending-request flags for a small 8-bit processor. It also decides which pending source the processor should take next. Five peripheral request lines set flag bits. A byte-wide register bus lets software read and replace both registers. Two outputs describe the combined state:
- `irq_any` is high when any enabled source is pending.
- `irq_id` is the index of the source to service next, chosen by fixed priority. Source 0 is highest and source 4 is lowest.

Source 0 is the frame-blank event. When its request line pulses, a short hold-off starts. During the hold-off, source 0 cannot be selected, even though it is pending and enabled, and a lower pending source may win instead. The `dbl_speed` input suppresses the start of this hold-off. When the processor takes an interrupt, it pulses `irq_ack`, and the flag of the selected source is cleared.

Top module: `irq_prio_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the enable register, the flag register and the hold-off counter. After reset, `irq_any` is 0, `irq_id` is 7 (the "none" code) and `bus_rdata` is 0x00.
- R2: A bus write to address 0xFFFF replaces all eight enable bits. The read data is registered: `bus_rdata` shows the register selected by `bus_addr` one clock after that address is presented, and it shows the register contents as they stood before that edge.
- R3: A bus write to address 0xFF0F replaces the five flag bits with `bus_wdata[4:0]`. Reading that address returns the flags in bits 4..0, and bits 7..5 always read as 1.
- R4: Each `irq_req[i]` that is high at a clock edge sets flag bit i and leaves the other flag bits unchanged. A request in the same cycle as a flag write is ORed onto the written value.
- R5: `irq_any` is high exactly when (enable bits 4..0 AND flag bits 4..0) is nonzero. Enable bits 7..5 do not affect it, and neither does the hold-off.
- R6: `irq_id` gives the lowest-numbered source that is both enabled and pending, as a value 0 to 4. The value 7 means none.
- R7: A high `irq_req[0]` with `dbl_speed` low loads the hold-off counter with 4. The counter then counts down by one per clock and stops at zero. While it is nonzero, source 0 is excluded from selection, so it is not selectable for the 4 cycles that follow the request edge.
- R8: A high `irq_req[0]` with `dbl_speed` high does not load the counter, so source 0 can be selected in the very next cycle.
- R9: `irq_ack` clears only the flag bit named by the current `irq_id`, at the same edge. When `irq_id` is 7, `irq_ack` has no effect. A flag write in the same cycle takes precedence over the clear, and a request for the same bit in the same cycle keeps the bit set.
- R10: A new `irq_req[0]` while the hold-off is running reloads the counter to the full 4 cycles.
- R11: An address that is neither 0xFFFF nor 0xFF0F reads as 0xFF, and a write to it changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | Register bus address |
| bus_wr | input | 1 | Register bus write strobe |
| bus_wdata | input | 8 | Register bus write data |
| bus_rdata | output | 8 | Registered read data for the address of the previous cycle |
| irq_req | input | 5 | Peripheral request lines, one cycle per request |
| dbl_speed | input | 1 | Double-speed mode, suppresses the source-0 hold-off |
| irq_ack | input | 1 | Processor took the selected interrupt; clear its flag |
| irq_any | output | 1 | An enabled source is pending |
| irq_id | output | 3 | Next source to service, 0..4, or 7 for none |

## Verification
The hardest state to reach from the ports is the one where source 0 is pending and enabled but still inside its hold-off window, with a lower source also pending. The stimulus has to raise source 0 through its request line, because a flag write does not arm the counter. It then has to sample on each of the following four cycles to see the lower source win and then lose to source 0.

The retrigger case is produced by pulsing the source-0 request again in the middle of the window. The double-speed case is produced by the same pulse with `dbl_speed` high. All enable and flag combinations of the low five bits are swept through the bus, and each result is compared against a priority model computed in the bench.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int unsigned SRC_N = 5;
  localparam int unsigned ID_W  = 3;
  typedef logic [ID_W-1:0]  src_id_t;
  typedef logic [SRC_N-1:0] src_vec_t;
  localparam src_id_t ID_NONE = '1;

  function automatic src_vec_t id_to_mask(src_id_t id);
    src_vec_t m;
    m = '0;
    for (int i = 0; i < SRC_N; i++) begin
      if (id == src_id_t'(i)) m[i] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/irq_regfile.sv
module irq_regfile
  import irq_prio_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ena,
  input  logic              wr_flg,
  input  logic [DATA_W-1:0] wdata,
  input  src_vec_t          req,
  input  src_vec_t          clr,
  output logic [DATA_W-1:0] ena_q,
  output src_vec_t          flg_q
);
  src_vec_t flg_base;

  // The write has priority over the clear; requests always OR on top.
  always_comb begin
    if (wr_flg) flg_base = wdata[SRC_N-1:0];
    else        flg_base = flg_q & ~clr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ena_q <= '0;
      flg_q <= '0;
    end else begin
      if (wr_ena) ena_q <= wdata;
      flg_q <= flg_base | req;
    end
  end
endmodule

// File: rtl/irq_holdoff.sv
module irq_holdoff #(
  parameter int unsigned HOLD_CYCLES = 4,
  parameter int unsigned CNT_W       = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm,
  output logic             busy,
  output logic [CNT_W-1:0] cnt_q
);
  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (arm)           cnt_q <= CNT_W'(HOLD_CYCLES);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_prio_pkg::*;
(
  input  src_vec_t pend,
  input  logic     mask_top,
  output src_id_t  id
);
  src_vec_t elig;

  // Scan from lowest priority up so the highest-priority bit lands last.
  always_comb begin
    elig = pend;
    if (mask_top) elig[0] = 1'b0;
    id = ID_NONE;
    for (int i = SRC_N - 1; i >= 0; i--) begin
      if (elig[i]) id = src_id_t'(i);
    end
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned DATA_W      = 8,
  parameter logic [ADDR_W-1:0] ENA_ADDR = 'hFFFF,
  parameter logic [ADDR_W-1:0] FLG_ADDR = 'hFF0F,
  parameter int unsigned HOLD_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [SRC_N-1:0]  irq_req,
  input  logic              dbl_speed,
  input  logic              irq_ack,
  output logic              irq_any,
  output logic [ID_W-1:0]   irq_id
);
  localparam int unsigned CNT_W = $clog2(HOLD_CYCLES + 1);
  localparam int unsigned PAD_W = DATA_W - SRC_N;

  logic [DATA_W-1:0] ena_q;
  src_vec_t          flg_q;
  src_vec_t          pend;
  src_vec_t          clr;
  src_id_t           sel;
  logic              hold_busy;
  logic [CNT_W-1:0]  hold_cnt;
  logic              wr_ena;
  logic              wr_flg;

  assign wr_ena = bus_wr && (bus_addr == ENA_ADDR);
  assign wr_flg = bus_wr && (bus_addr == FLG_ADDR);
  assign clr    = (irq_ack && sel != ID_NONE) ? id_to_mask(sel) : '0;

  irq_regfile #(.DATA_W(DATA_W)) u_regs (
    .clk    (clk),
    .rst    (rst),
    .wr_ena (wr_ena),
    .wr_flg (wr_flg),
    .wdata  (bus_wdata),
    .req    (irq_req),
    .clr    (clr),
    .ena_q  (ena_q),
    .flg_q  (flg_q)
  );

  irq_holdoff #(.HOLD_CYCLES(HOLD_CYCLES), .CNT_W(CNT_W)) u_hold (
    .clk   (clk),
    .rst   (rst),
    .arm   (irq_req[0] && !dbl_speed),
    .busy  (hold_busy),
    .cnt_q (hold_cnt)
  );

  assign pend = ena_q[SRC_N-1:0] & flg_q;

  irq_pick u_pick (
    .pend     (pend),
    .mask_top (hold_busy),
    .id       (sel)
  );

  assign irq_any = |pend;
  assign irq_id  = sel;

  always_ff @(posedge clk) begin
    if (rst)                        bus_rdata <= '0;
    else if (bus_addr == ENA_ADDR)  bus_rdata <= ena_q;
    else if (bus_addr == FLG_ADDR)  bus_rdata <= {{PAD_W{1'b1}}, flg_q};
    else                            bus_rdata <= '1;
  end
endmodule

// File: rtl/irq_prio_checker.sv
module irq_prio_checker
  import irq_prio_pkg::*;
#(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned DATA_W      = 8,
  parameter logic [ADDR_W-1:0] FLG_ADDR = 'hFF0F,
  parameter int unsigned HOLD_CYCLES = 4,
  parameter int unsigned CNT_W       = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [SRC_N-1:0]  irq_req,
  input logic              dbl_speed,
  input logic              irq_ack,
  input logic              irq_any,
  input logic [ID_W-1:0]   irq_id,
  input logic [DATA_W-1:0] ena_q,
  input logic [SRC_N-1:0]  flg_q,
  input logic [CNT_W-1:0]  hold_cnt
);
  a_r6_sel_is_pending: assert property (@(posedge clk) disable iff (rst)
    (irq_id != ID_NONE) |-> ((ena_q[SRC_N-1:0] & flg_q & id_to_mask(irq_id)) != '0));

  a_r6_lower_not_dropped: assert property (@(posedge clk) disable iff (rst)
    ((ena_q[SRC_N-1:0] & flg_q & ~SRC_N'(1)) != '0) |-> (irq_id != ID_NONE));

  a_r5_any_covers_sel: assert property (@(posedge clk) disable iff (rst)
    (irq_id != ID_NONE) |-> irq_any);

  a_r7_top_blocked: assert property (@(posedge clk) disable iff (rst)
    (hold_cnt != '0) |-> (irq_id != '0));

  a_r7_arm_loads: assert property (@(posedge clk) disable iff (rst)
    (irq_req[0] && !dbl_speed) |=> (hold_cnt == CNT_W'(HOLD_CYCLES)));

  a_r4_req_sets: assert property (@(posedge clk) disable iff (rst)
    (irq_req != '0) |=> ((flg_q & $past(irq_req)) == $past(irq_req)));

  a_r9_ack_clears: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && irq_id != ID_NONE && !(bus_wr && bus_addr == FLG_ADDR)
     && ((irq_req & id_to_mask(irq_id)) == '0))
    |=> ((flg_q & id_to_mask($past(irq_id))) == '0));
endmodule

bind irq_prio_ctrl irq_prio_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FLG_ADDR(FLG_ADDR),
  .HOLD_CYCLES(HOLD_CYCLES), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .irq_req(irq_req), .dbl_speed(dbl_speed), .irq_ack(irq_ack),
  .irq_any(irq_any), .irq_id(irq_id), .ena_q(ena_q), .flg_q(flg_q),
  .hold_cnt(hold_cnt)
);

// File: tb/irq_prio_ctrl_bench.sv
module irq_prio_ctrl_bench;
  localparam int CLK_P = 10;
  localparam logic [15:0] A_ENA = 16'hFFFF;
  localparam logic [15:0] A_FLG = 16'hFF0F;
  localparam logic [15:0] A_OTH = 16'hFF10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] bus_addr = 16'h0000;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = 8'h00;
  logic [7:0]  bus_rdata;
  logic [4:0]  irq_req = 5'b0;
  logic        dbl_speed = 1'b0;
  logic        irq_ack = 1'b0;
  logic        irq_any;
  logic [2:0]  irq_id;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string cur_tag = "R1";

  logic [7:0] m_ena = 8'h00;
  logic [4:0] m_flg = 5'h00;
  int         m_cnt = 0;
  logic [7:0] m_rd  = 8'h00;

  always #(CLK_P/2) clk = ~clk;

  irq_prio_ctrl u_irq_prio_ctrl (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_req(irq_req),
    .dbl_speed(dbl_speed), .irq_ack(irq_ack), .irq_any(irq_any), .irq_id(irq_id)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int model_id();
    logic [4:0] p;
    p = m_ena[4:0] & m_flg;
    if (m_cnt != 0) p[0] = 1'b0;
    for (int i = 0; i < 5; i++) if (p[i]) return i;
    return 7;
  endfunction

  task automatic tick();
    logic [7:0] n_ena, n_rd;
    logic [4:0] n_flg, clr;
    int n_cnt, id;
    id  = model_id();
    clr = (irq_ack && id != 7) ? (5'b1 << id) : 5'b0;
    n_ena = (bus_wr && bus_addr == A_ENA) ? bus_wdata : m_ena;
    n_flg = ((bus_wr && bus_addr == A_FLG) ? bus_wdata[4:0] : (m_flg & ~clr)) | irq_req;
    n_cnt = (irq_req[0] && !dbl_speed) ? 4 : ((m_cnt > 0) ? m_cnt - 1 : 0);
    n_rd  = (bus_addr == A_ENA) ? m_ena : (bus_addr == A_FLG) ? {3'b111, m_flg} : 8'hFF;
    if (rst) begin
      n_ena = 8'h00; n_flg = 5'h00; n_cnt = 0; n_rd = 8'h00;
    end
    @(posedge clk);
    @(negedge clk);
    m_ena = n_ena; m_flg = n_flg; m_cnt = n_cnt; m_rd = n_rd;
    chk({cur_tag, " any"}, int'(irq_any), int'(|(m_ena[4:0] & m_flg)));
    chk({cur_tag, " id"}, int'(irq_id), model_id());
    chk({cur_tag, " rdata"}, int'(bus_rdata), int'(m_rd));
  endtask

  task automatic wr_reg(logic [15:0] a, logic [7:0] d);
    bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    tick();
    bus_wr = 1'b0;
  endtask

  task automatic rd_reg(logic [15:0] a, logic [7:0] exp, string tag);
    bus_addr = a;
    tick();
    chk(tag, int'(bus_rdata), int'(exp));
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        checks++; errors++;
        $display("FAIL watchdog actual %0d expected below 100000", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    cur_tag = "R1";
    tick(); tick();
    rst = 1'b0;
    chk("R1 any", int'(irq_any), 0);
    chk("R1 id", int'(irq_id), 7);
    chk("R1 rdata", int'(bus_rdata), 0);
    rd_reg(A_ENA, 8'h00, "R1 ena");
    rd_reg(A_FLG, 8'hE0, "R1 flg");

    cur_tag = "R2";
    wr_reg(A_ENA, 8'hA5);
    rd_reg(A_ENA, 8'hA5, "R2 readback");

    cur_tag = "R3";
    wr_reg(A_FLG, 8'h1F);
    rd_reg(A_FLG, 8'hFF, "R3 all set");
    wr_reg(A_FLG, 8'h00);
    rd_reg(A_FLG, 8'hE0, "R3 upper ones");

    cur_tag = "R11";
    wr_reg(A_OTH, 8'h3C);
    rd_reg(A_OTH, 8'hFF, "R11 unmapped read");
    rd_reg(A_ENA, 8'hA5, "R11 ena kept");
    rd_reg(A_FLG, 8'hE0, "R11 flg kept");

    cur_tag = "R6";
    for (int e = 0; e < 32; e++) begin
      for (int f = 0; f < 32; f++) begin
        wr_reg(A_ENA, {3'(e), 5'(e)});
        wr_reg(A_FLG, {3'b000, 5'(f)});
        bus_addr = A_FLG;
        cur_tag = "R5";
        tick();
        cur_tag = "R6";
      end
    end

    cur_tag = "R4";
    wr_reg(A_ENA, 8'h00);
    wr_reg(A_FLG, 8'h04);
    irq_req = 5'b01001; tick(); irq_req = 5'b0;
    rd_reg(A_FLG, 8'hED, "R4 or");
    bus_addr = A_FLG; bus_wr = 1'b1; bus_wdata = 8'h02; irq_req = 5'b10000;
    tick(); bus_wr = 1'b0; irq_req = 5'b0;
    rd_reg(A_FLG, 8'hF2, "R4 write plus req");

    cur_tag = "R7";
    wr_reg(A_ENA, 8'h1F);
    wr_reg(A_FLG, 8'h00);
    irq_req = 5'b00101; tick(); irq_req = 5'b0;
    chk("R7 lower wins", int'(irq_id), 2);
    tick(); tick(); tick();
    chk("R7 still blocked", int'(irq_id), 2);
    tick();
    chk("R7 released", int'(irq_id), 0);
    wr_reg(A_FLG, 8'h00);
    irq_req = 5'b00001; tick(); irq_req = 5'b0;
    chk("R7 none while held", int'(irq_id), 7);
    chk("R7 any while held", int'(irq_any), 1);
    tick(); tick(); tick(); tick();

    cur_tag = "R8";
    wr_reg(A_FLG, 8'h00);
    dbl_speed = 1'b1; irq_req = 5'b00001; tick(); irq_req = 5'b0;
    chk("R8 immediate", int'(irq_id), 0);
    dbl_speed = 1'b0;

    cur_tag = "R10";
    wr_reg(A_FLG, 8'h00);
    irq_req = 5'b00001; tick(); irq_req = 5'b0;
    tick(); tick();
    irq_req = 5'b00001; tick(); irq_req = 5'b0;
    tick(); tick(); tick();
    chk("R10 reloaded", int'(irq_id), 7);
    tick();
    chk("R10 release", int'(irq_id), 0);

    cur_tag = "R9";
    wr_reg(A_FLG, 8'h05);
    irq_ack = 1'b1; tick();
    chk("R9 clear top", int'(irq_id), 2);
    rd_reg(A_FLG, 8'hE4, "R9 only one cleared");
    irq_req = 5'b00100; tick(); irq_req = 5'b0;
    chk("R9 req keeps bit", int'(irq_id), 2);
    tick();
    chk("R9 clear last", int'(irq_id), 7);
    wr_reg(A_ENA, 8'h00);
    wr_reg(A_FLG, 8'h1F);
    rd_reg(A_FLG, 8'hFF, "R9 ack with none");
    irq_ack = 1'b0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule